// File: doc/BRIEF.md
# Neutral-Point Balancing PI Regulator

A three-level inverter keeps its DC link on two capacitors in series. When the charge they carry drifts apart, the midpoint voltage moves, and the phase outputs distort. This block closes the balancing loop. It takes one signed sample of each capacitor voltage, together with a strobe. From each pair it forms the balancing error, with a target of zero imbalance, and runs a discrete proportional-integral law on it. It returns one signed common-mode offset word. The PWM modulator adds this word equally to all three phase references.

The gains are fixed-point constants of 0.1 and 0.01 in a 16-bit fraction format, and each product is rounded to the nearest step. The output is clamped to a symmetric limit. The integrator stops accumulating in the direction that would push the output further into that limit, so it recovers at once when the error reverses. An enable input switches the loop in or out at run time. While the loop is out, the integrator is cleared and the offset is forced to zero. A result leaves the block two cycles after its sample arrives, and a new sample can be accepted on every cycle.

Top module: `np_balance_pi`

## Requirements
- R1: While reset is held and after it is released, `valid_o` is 0 and `offset_o` is 0 until the first sample is processed.
- R2: The error is `v_lo_i - v_hi_i`, which is the zero setpoint minus the upper-minus-lower difference. An upper capacitor that is higher than the lower one yields a negative offset.
- R3: The proportional term is err*6554/65536 and the integral increment is err*655/65536. Each is rounded separately to the nearest integer, with a fraction of exactly one half rounding toward plus infinity. The output is the proportional term plus the updated integral.
- R4: The integral accumulates once per accepted sample. Changes on `v_hi_i`/`v_lo_i` while `valid_i` is 0 affect neither the integral nor `offset_o`, which holds between strobes.
- R5: `offset_o` is saturated to the range -8192..+8192 (OUT_LIM), and the integral is clamped to the same range.
- R6: Anti-windup applies when the sum of the proportional term and the previous integral lies beyond OUT_LIM in one direction and the new increment points the same way. The integral then holds instead of accumulating. After the error reverses, the first output therefore falls well inside the limit.
- R7: While `en_i` is 0, the integral is cleared and `offset_o` is 0 from the next cycle on. Strobed samples still produce `valid_o` with a zero offset. After `en_i` returns to 1, the loop restarts from a zero integral.
- R8: `valid_o` is a one-cycle pulse exactly two clock cycles after each `valid_i` pulse, and it never asserts otherwise.
- R9: Samples on consecutive cycles each produce a result on consecutive cycles, in order, and each result uses the integral left by the sample before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loop enable; 0 clears the integral and zeroes the offset |
| valid_i | input | 1 | Sample strobe |
| v_hi_i | input | DATA_W | Upper capacitor voltage, signed |
| v_lo_i | input | DATA_W | Lower capacitor voltage, signed |
| valid_o | output | 1 | Offset strobe, two cycles after `valid_i` |
| offset_o | output | OUT_W | Common-mode offset, signed, saturated |

## Verification
In the same cycle, the regulator can make both of its limiting decisions. One is whether the output saturates. The other is whether anti-windup freezes the integral, because the proportional part plus the integral already exceeds the limit. A sustained large error of each sign provokes both: first the output reaches the limit, and then later samples arrive with the integral frozen. The result is judged by the pinned output value. It is also judged by the first sample after a small reversed error, whose output must equal the proportional term plus a barely changed integral, far below the limit.

// File: rtl/np_pi_pkg.sv
package np_pi_pkg;
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_dir_e;

  localparam int unsigned NP_FRAC_DEF = 16;
endpackage

// File: rtl/np_err_stage.sv
module np_err_stage #(
  parameter int DATA_W = 16,
  localparam int EW = DATA_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] v_hi_i,
  input  logic signed [DATA_W-1:0] v_lo_i,
  output logic signed [EW-1:0]     err_o,
  output logic                     valid_o
);
  // zero setpoint: err = 0 - (hi - lo)
  logic signed [EW-1:0] err_d;
  assign err_d = EW'(v_lo_i) - EW'(v_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) err_o <= err_d;
    end
  end
endmodule

// File: rtl/np_qmul.sv
module np_qmul #(
  parameter int IN_W  = 19,
  parameter int K_W   = 18,
  parameter int FRAC  = 16,
  parameter int OUT_W = 19,
  parameter int K     = 6554
) (
  input  logic signed [IN_W-1:0]  a_i,
  output logic signed [OUT_W-1:0] p_o
);
  localparam int PR_W = IN_W + K_W;
  localparam logic signed [K_W-1:0]  KC   = K_W'(K);
  localparam logic signed [PR_W-1:0] HALF = PR_W'(longint'(1) <<< (FRAC - 1));

  logic signed [PR_W-1:0] prod;
  logic signed [PR_W-1:0] rnd;

  assign prod = PR_W'(a_i) * PR_W'(KC);
  // round to nearest, ties toward +inf
  assign rnd  = (prod + HALF) >>> FRAC;
  assign p_o  = OUT_W'(rnd);
endmodule

// File: rtl/np_limiter.sv
module np_limiter #(
  parameter int W   = 19,
  parameter int LIM = 8192
) (
  input  logic signed [W-1:0] val_i,
  output logic signed [W-1:0] val_o
);
  localparam logic signed [W-1:0] HI = W'(LIM);
  localparam logic signed [W-1:0] LO = W'(-LIM);

  always_comb begin
    if (val_i > HI)      val_o = HI;
    else if (val_i < LO) val_o = LO;
    else                 val_o = val_i;
  end
endmodule

// File: rtl/np_integ.sv
module np_integ
  import np_pi_pkg::*;
#(
  parameter int ACC_W = 19,
  parameter int LIM   = 8192
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    upd_i,
  input  logic signed [ACC_W-1:0] p_i,
  input  logic signed [ACC_W-1:0] ki_i,
  output logic signed [ACC_W-1:0] nxt_o
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(LIM);
  localparam logic signed [ACC_W-1:0] LO = ACC_W'(-LIM);

  logic signed [ACC_W-1:0] integ_q;
  logic signed [ACC_W-1:0] trial;
  logic signed [ACC_W-1:0] cand;
  logic signed [ACC_W-1:0] cand_lim;
  sat_dir_e                dir;
  logic                    ki_pos;
  logic                    ki_neg;
  logic                    hold;

  assign trial  = p_i + integ_q;
  assign cand   = integ_q + ki_i;
  assign ki_neg = ki_i[ACC_W-1];
  assign ki_pos = !ki_neg && (ki_i != '0);

  always_comb begin
    if (trial > HI)      dir = SAT_HI;
    else if (trial < LO) dir = SAT_LO;
    else                 dir = SAT_NONE;
  end

  // freeze only when the increment pushes deeper into the active limit
  assign hold = ((dir == SAT_HI) && ki_pos) || ((dir == SAT_LO) && ki_neg);

  np_limiter #(.W(ACC_W), .LIM(LIM)) u_clamp (
    .val_i(cand),
    .val_o(cand_lim)
  );

  assign nxt_o = hold ? integ_q : cand_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     integ_q <= '0;
    else if (!en_i)  integ_q <= '0;
    else if (upd_i)  integ_q <= nxt_o;
  end
endmodule

// File: rtl/np_balance_pi.sv
module np_balance_pi #(
  parameter int DATA_W  = 16,
  parameter int OUT_W   = 16,
  parameter int FRAC    = 16,
  parameter int KP_Q    = 6554,
  parameter int KI_Q    = 655,
  parameter int OUT_LIM = 8192
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] v_hi_i,
  input  logic signed [DATA_W-1:0] v_lo_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  offset_o
);
  localparam int EW    = DATA_W + 1;
  localparam int ACC_W = DATA_W + 3;
  localparam int K_W   = FRAC + 2;
  localparam int N_GAIN = 2;

  logic signed [EW-1:0]    err_q;
  logic                    v1_q;
  logic signed [ACC_W-1:0] err_ext;
  logic signed [ACC_W-1:0] term [N_GAIN];
  logic signed [ACC_W-1:0] integ_nxt;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] sum_lim;
  logic signed [OUT_W-1:0] out_q;
  logic                    vo_q;

  np_err_stage #(.DATA_W(DATA_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .v_hi_i (v_hi_i),
    .v_lo_i (v_lo_i),
    .err_o  (err_q),
    .valid_o(v1_q)
  );

  assign err_ext = ACC_W'(err_q);

  // term[0] proportional, term[1] integral increment
  for (genvar g = 0; g < N_GAIN; g++) begin : g_gain
    np_qmul #(
      .IN_W (ACC_W),
      .K_W  (K_W),
      .FRAC (FRAC),
      .OUT_W(ACC_W),
      .K    ((g == 0) ? KP_Q : KI_Q)
    ) u_mul (
      .a_i(err_ext),
      .p_o(term[g])
    );
  end

  np_integ #(.ACC_W(ACC_W), .LIM(OUT_LIM)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .upd_i (v1_q),
    .p_i   (term[0]),
    .ki_i  (term[1]),
    .nxt_o (integ_nxt)
  );

  assign sum = term[0] + integ_nxt;

  np_limiter #(.W(ACC_W), .LIM(OUT_LIM)) u_out_lim (
    .val_i(sum),
    .val_o(sum_lim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      vo_q  <= 1'b0;
    end else begin
      vo_q <= v1_q;
      if (!en_i)     out_q <= '0;
      else if (v1_q) out_q <= OUT_W'(sum_lim);
    end
  end

  assign valid_o  = vo_q;
  assign offset_o = out_q;
endmodule

// File: rtl/np_balance_pi_chk.sv
module np_balance_pi_chk #(
  parameter int OUT_W   = 16,
  parameter int OUT_LIM = 8192
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] offset_o
);
  localparam logic signed [OUT_W-1:0] HI = OUT_W'(OUT_LIM);
  localparam logic signed [OUT_W-1:0] LO = OUT_W'(-OUT_LIM);

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_o <= HI) && (offset_o >= LO));

  a_r7_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (offset_o == '0));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && $past(en_i)) |-> $stable(offset_o));
endmodule

bind np_balance_pi np_balance_pi_chk #(.OUT_W(OUT_W), .OUT_LIM(OUT_LIM)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .offset_o(offset_o)
);

// File: tb/test_np_balance_pi.sv
`timescale 1ns/1ps
module test_np_balance_pi;
  localparam longint LIM = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic vin = 1'b0;
  logic signed [15:0] hi = '0;
  logic signed [15:0] lo = '0;
  logic vout;
  logic signed [15:0] offset;

  int n_chk = 0;
  int n_err = 0;
  longint integ_m = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  np_balance_pi i_np_balance_pi (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .valid_i(vin),
    .v_hi_i(hi), .v_lo_i(lo), .valid_o(vout), .offset_o(offset)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint qr(input longint e, input longint k);
    return (e * k + 32768) >>> 16;
  endfunction

  function automatic longint clampv(input longint x);
    if (x > LIM) return LIM;
    if (x < -LIM) return -LIM;
    return x;
  endfunction

  // expected result of one sample, from the requirement text
  task automatic model(input int hv, input int lv, output longint exp);
    longint e, p, k, trial;
    bit hold;
    e = longint'(lv) - longint'(hv);
    p = qr(e, 6554);
    k = qr(e, 655);
    if (!en) begin
      integ_m = 0;
      exp = 0;
      return;
    end
    trial = p + integ_m;
    hold = ((trial > LIM) && (k > 0)) || ((trial < -LIM) && (k < 0));
    if (!hold) integ_m = clampv(integ_m + k);
    exp = clampv(p + integ_m);
  endtask

  task automatic sample(input int hv, input int lv, input string tag);
    longint exp;
    model(hv, lv, exp);
    @(negedge clk); hi = 16'(hv); lo = 16'(lv); vin = 1'b1;
    @(negedge clk); vin = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, longint'(vout), 1);
    chk(tag, longint'(offset), exp);
  endtask

  task automatic t_reset;
    chk("R1 valid in reset", longint'(vout), 0);
    chk("R1 offset in reset", longint'(offset), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", longint'(vout), 0);
    chk("R1 offset after reset", longint'(offset), 0);
  endtask

  task automatic t_sign;
    sample(5000, 3000, "R2 upper high gives -220");
    chk("R2 sign negative", longint'(offset < 0), 1);
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
    sample(3000, 5000, "R2 lower high gives +220");
    chk("R2 value", longint'(offset), 220);
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
  endtask

  task automatic t_round;
    sample(0, 10, "R3 err=10");
    chk("R3 err=10 is 1", longint'(offset), 1);
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
    sample(5, 0, "R3 err=-5 rounds to -1");
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
    sample(0, 12345, "R3 err=12345");
  endtask

  task automatic t_latency;
    longint exp;
    model(2000, 1000, exp);
    @(negedge clk); hi = 16'sd2000; lo = 16'sd1000; vin = 1'b1;
    @(negedge clk); vin = 1'b0;
    chk("R8 no valid after 1 cycle", longint'(vout), 0);
    @(negedge clk);
    chk("R8 valid after 2 cycles", longint'(vout), 1);
    chk("R8 value", longint'(offset), exp);
    @(negedge clk);
    chk("R8 one-cycle pulse", longint'(vout), 0);
  endtask

  task automatic t_accum;
    longint held;
    for (int i = 0; i < 4; i++) sample(1000, 1500, "R4 accumulate");
    held = longint'(offset);
    @(negedge clk); hi = 16'sd20000; lo = -16'sd20000;
    repeat (5) @(negedge clk);
    chk("R4 unstrobed inputs ignored", longint'(offset), held);
    chk("R4 no valid without strobe", longint'(vout), 0);
    sample(1000, 1500, "R4 integral untouched by unstrobed data");
  endtask

  task automatic t_windup;
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
    for (int i = 0; i < 22; i++) sample(0, 30000, "R5 drive to +limit");
    chk("R5 pinned at +8192", longint'(offset), 8192);
    sample(1000, 0, "R6 immediate recovery");
    chk("R6 well below limit", longint'(offset < 6000), 1);
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
    for (int i = 0; i < 22; i++) sample(30000, 0, "R5 drive to -limit");
    chk("R5 pinned at -8192", longint'(offset), -8192);
    sample(0, 1000, "R6 immediate recovery negative");
    chk("R6 well above -limit", longint'(offset > -6000), 1);
  endtask

  task automatic t_disable;
    for (int i = 0; i < 3; i++) sample(0, 8000, "R7 build integral");
    @(negedge clk); en = 1'b0; integ_m = 0;
    @(negedge clk);
    chk("R7 offset zero when disabled", longint'(offset), 0);
    sample(0, 8000, "R7 sample while disabled");
    @(negedge clk); en = 1'b1;
    sample(5000, 3000, "R7 restart from zero integral");
    chk("R7 restart value", longint'(offset), -220);
  endtask

  task automatic t_stream;
    longint e0, e1, e2;
    en = 1'b0; integ_m = 0; @(negedge clk); en = 1'b1;
    model(0, 4000, e0);
    model(0, -3000, e1);
    model(100, 7000, e2);
    @(negedge clk); hi = 16'sd0;   lo = 16'sd4000;  vin = 1'b1;
    @(negedge clk); hi = 16'sd0;   lo = -16'sd3000;
    @(negedge clk); hi = 16'sd100; lo = 16'sd7000;
    chk("R9 first result", longint'(offset), e0);
    @(negedge clk); vin = 1'b0;
    chk("R9 second valid", longint'(vout), 1);
    chk("R9 second result", longint'(offset), e1);
    @(negedge clk);
    chk("R9 third result", longint'(offset), e2);
    @(negedge clk);
    chk("R9 stream ends", longint'(vout), 0);
  endtask

  initial begin
    t_reset();
    t_sign();
    t_round();
    t_latency();
    t_accum();
    t_windup();
    t_disable();
    t_stream();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule